// File: doc/BRIEF.md
# Lenient Two-Way Predicated Selector Stage

This block is the control and data register of one pipeline stage that picks one of two data inputs under the control of two predicate inputs. All five channels use a four-phase request/acknowledge handshake. Each channel is modeled as clocked levels. Each of the two data channels brings a word. Each of the two predicate channels brings a single value bit. The stage drives one output channel.

The output side is lenient. It may fire as soon as one predicate has arrived true and the data word it selects has arrived, without waiting for the other inputs. If both predicates arrive false and both data words are present, the stage still fires and repeats the word it last emitted. The input side is strict: the stage returns acknowledgements only once every input channel holds a request. It then releases each acknowledgement separately as that channel withdraws its request.

An internal flag allows one output transfer per input round. A round ends when every input acknowledgement has returned low.

Top module: `lenient_sel_stage`

## Requirements
- R1: With predicate 0 valid and true (`sel0_req`=1, `sel0_val`=1), `in0_req`=1, and `out_ack`, `out_req` and the round flag all low, `out_req` is 1 and `out_data` equals `in0_data` one clock later. The state of the other inputs does not matter.
- R2: The same rule holds for predicate 1 and data channel 1: the stage emits `in1_data` one clock later.
- R3: With both predicate requests high, both values 0 and both data requests high, `out_req` rises one clock later and `out_data` repeats the last emitted word.
- R4: `out_req` never rises while `out_ack` is high.
- R5: The four input acknowledgements rise on the same clock edge. They rise one clock after a cycle in which all four input requests are high, `out_ack` is low, and the round's output has been produced or is being produced in that cycle.
- R6: Each input acknowledgement falls one clock after its own request is seen low. The others stay high.
- R7: `out_req` falls one clock after `out_ack` is seen high while `out_req` is high. `out_data` holds its value.
- R8: A predicate value bit counts only while its request is high. A set value with its request low acts as false.
- R9: Within one input round the output fires at most once, even when its handshake completes while the inputs are still held.
- R10: Reset is synchronous and active high. It drives `out_req`, `out_data`, all acknowledgements and the held word to zero, so a stale emission right after reset outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in0_req | input | 1 | Data channel 0 request |
| in0_data | input | DATA_W | Data channel 0 word |
| in0_ack | output | 1 | Data channel 0 acknowledge |
| in1_req | input | 1 | Data channel 1 request |
| in1_data | input | DATA_W | Data channel 1 word |
| in1_ack | output | 1 | Data channel 1 acknowledge |
| sel0_req | input | 1 | Predicate channel 0 request |
| sel0_val | input | 1 | Predicate channel 0 value |
| sel0_ack | output | 1 | Predicate channel 0 acknowledge |
| sel1_req | input | 1 | Predicate channel 1 request |
| sel1_val | input | 1 | Predicate channel 1 value |
| sel1_ack | output | 1 | Predicate channel 1 acknowledge |
| out_req | output | 1 | Output channel request |
| out_ack | input | 1 | Output channel acknowledge |
| out_data | output | DATA_W | Output word |

## Verification
Each round of the stimulus table first presents predicate 0 with data 0 alone, and only then the other two inputs. A true predicate 0 must fire at once. A false one must not fire, and the data word emitted later shows whether channel 1 or the held word was chosen. In each round the output handshake completes while all inputs are still held, which exposes any second firing. Requests are then withdrawn one channel at a time, which shows whether the acknowledgements are released separately. Directed cases set a predicate value without its request, hold `out_ack` high while every input is present, and apply a reset in the middle of the run followed by a stale emission.

// File: rtl/lenient_sel_pkg.sv
package lenient_sel_pkg;
  // source chosen for the output in a given cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CH0  = 2'd1,
    SRC_CH1  = 2'd2,
    SRC_HELD = 2'd3
  } src_e;

  localparam int unsigned NUM_WAYS = 2;
  localparam int unsigned NUM_IN   = 2 * NUM_WAYS;
endpackage

// File: rtl/lenient_sel_decode.sv
module lenient_sel_decode
  import lenient_sel_pkg::*;
#(
  parameter int unsigned WAYS = NUM_WAYS
) (
  input  logic [WAYS-1:0] dat_req,
  input  logic [WAYS-1:0] prd_req,
  input  logic [WAYS-1:0] prd_val,
  output src_e            src
);
  logic [WAYS-1:0] prd_true;
  logic [WAYS-1:0] prd_false;
  logic [WAYS-1:0] way_hit;

  // a value bit only counts while its request is high
  for (genvar w = 0; w < WAYS; w++) begin : g_gate
    assign prd_true[w]  = prd_req[w] &  prd_val[w];
    assign prd_false[w] = prd_req[w] & ~prd_val[w];
    assign way_hit[w]   = prd_true[w] & dat_req[w];
  end

  logic stale_ok;
  assign stale_ok = (&prd_false) & (&dat_req);

  always_comb begin
    src = SRC_NONE;
    if (way_hit[0])      src = SRC_CH0;
    else if (way_hit[1]) src = SRC_CH1;
    else if (stale_ok)   src = SRC_HELD;
  end
endmodule

// File: rtl/lenient_sel_out.sv
module lenient_sel_out
  import lenient_sel_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  src_e              src,
  input  logic [DATA_W-1:0] data0,
  input  logic [DATA_W-1:0] data1,
  input  logic              out_ack,
  input  logic              round_done,
  output logic              out_req,
  output logic [DATA_W-1:0] out_data,
  output logic              produced
);
  logic fired_q;
  logic fire_now;

  assign fire_now = (src != SRC_NONE) && !out_req && !out_ack && !fired_q;
  assign produced = fired_q | fire_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_req  <= 1'b0;
      out_data <= '0;
      fired_q  <= 1'b0;
    end else begin
      if (fire_now) begin
        out_req <= 1'b1;
        unique case (src)
          SRC_CH0: out_data <= data0;
          SRC_CH1: out_data <= data1;
          default: out_data <= out_data; // held word is the last emitted one
        endcase
      end else if (out_req && out_ack) begin
        out_req <= 1'b0;
      end
      if (fire_now)        fired_q <= 1'b1;
      else if (round_done) fired_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lenient_sel_ack.sv
module lenient_sel_ack #(
  parameter int unsigned CH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] reqs,
  input  logic          out_ack,
  input  logic          produced,
  output logic [CH-1:0] acks,
  output logic          round_done
);
  logic acked_q;
  logic ack_go;

  assign ack_go     = (&reqs) && !out_ack && produced && !acked_q;
  assign round_done = acked_q && (acks == '0);

  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)           acks[c] <= 1'b0;
      else if (ack_go)   acks[c] <= 1'b1;
      else if (!reqs[c]) acks[c] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             acked_q <= 1'b0;
    else if (ack_go)     acked_q <= 1'b1;
    else if (round_done) acked_q <= 1'b0;
  end
endmodule

// File: rtl/lenient_sel_stage.sv
module lenient_sel_stage
  import lenient_sel_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in0_req,
  input  logic [DATA_W-1:0] in0_data,
  output logic              in0_ack,
  input  logic              in1_req,
  input  logic [DATA_W-1:0] in1_data,
  output logic              in1_ack,
  input  logic              sel0_req,
  input  logic              sel0_val,
  output logic              sel0_ack,
  input  logic              sel1_req,
  input  logic              sel1_val,
  output logic              sel1_ack,
  output logic              out_req,
  input  logic              out_ack,
  output logic [DATA_W-1:0] out_data
);
  src_e              src;
  logic              produced;
  logic              round_done;
  logic [NUM_IN-1:0] all_req;
  logic [NUM_IN-1:0] all_ack;

  // channel order: {sel1, sel0, in1, in0}
  assign all_req = {sel1_req, sel0_req, in1_req, in0_req};
  assign {sel1_ack, sel0_ack, in1_ack, in0_ack} = all_ack;

  lenient_sel_decode #(.WAYS(NUM_WAYS)) u_dec (
    .dat_req ({in1_req, in0_req}),
    .prd_req ({sel1_req, sel0_req}),
    .prd_val ({sel1_val, sel0_val}),
    .src     (src)
  );

  lenient_sel_out #(.DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .src        (src),
    .data0      (in0_data),
    .data1      (in1_data),
    .out_ack    (out_ack),
    .round_done (round_done),
    .out_req    (out_req),
    .out_data   (out_data),
    .produced   (produced)
  );

  lenient_sel_ack #(.CH(NUM_IN)) u_ack (
    .clk        (clk),
    .rst        (rst),
    .reqs       (all_req),
    .out_ack    (out_ack),
    .produced   (produced),
    .acks       (all_ack),
    .round_done (round_done)
  );
endmodule

// File: rtl/lenient_sel_chk.sv
module lenient_sel_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in0_req,
  input logic              in1_req,
  input logic              sel0_req,
  input logic              sel1_req,
  input logic              in0_ack,
  input logic              in1_ack,
  input logic              sel0_ack,
  input logic              sel1_ack,
  input logic              out_req,
  input logic              out_ack,
  input logic [DATA_W-1:0] out_data
);
  logic [3:0] acks;
  logic [3:0] reqs;
  assign acks = {sel1_ack, sel0_ack, in1_ack, in0_ack};
  assign reqs = {sel1_req, sel0_req, in1_req, in0_req};

  // R7
  out_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (out_req && out_ack) |=> (!out_req && $stable(out_data)));

  // R4
  no_fire_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_req) |-> !$past(out_ack));

  // R5
  joint_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(in0_ack) || $rose(in1_ack) || $rose(sel0_ack) || $rose(sel1_ack))
      |-> ((acks == 4'hF) && $past(reqs == 4'hF) && !$past(out_ack)));

  // R6
  in0_release_chk: assert property (@(posedge clk) disable iff (rst)
    !in0_req |=> !in0_ack);

  // R6
  in1_release_chk: assert property (@(posedge clk) disable iff (rst)
    !in1_req |=> !in1_ack);

  // R6
  sel_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel0_req || !sel1_req) |=> (!(sel0_ack && !$past(sel0_req)) && !(sel1_ack && !$past(sel1_req))));
endmodule

bind lenient_sel_stage lenient_sel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in0_req  (in0_req),
  .in1_req  (in1_req),
  .sel0_req (sel0_req),
  .sel1_req (sel1_req),
  .in0_ack  (in0_ack),
  .in1_ack  (in1_ack),
  .sel0_ack (sel0_ack),
  .sel1_ack (sel1_ack),
  .out_req  (out_req),
  .out_ack  (out_ack),
  .out_data (out_data)
);

// File: tb/lenient_sel_stage_tb.sv
module lenient_sel_stage_tb;
  localparam int DW = 8;
  localparam int NV = 6;
  // each row: {sel0_val, sel1_val, in0_data, in1_data}
  localparam logic [2*DW+1:0] VECS [0:NV-1] = '{
    {2'b00, 8'h77, 8'h88},   // stale right after reset -> 0
    {2'b10, 8'hA5, 8'h3C},
    {2'b01, 8'h11, 8'h22},
    {2'b00, 8'h44, 8'h55},   // stale -> 22
    {2'b10, 8'hC3, 8'h99},
    {2'b01, 8'h0F, 8'hF0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in0_req = 0, in1_req = 0, sel0_req = 0, sel1_req = 0;
  logic sel0_val = 0, sel1_val = 0, out_ack = 0;
  logic [DW-1:0] in0_data = '0, in1_data = '0;
  logic in0_ack, in1_ack, sel0_ack, sel1_ack, out_req;
  logic [DW-1:0] out_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] held = '0;

  always #5 clk = ~clk;

  lenient_sel_stage #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .in0_req(in0_req), .in0_data(in0_data), .in0_ack(in0_ack),
    .in1_req(in1_req), .in1_data(in1_data), .in1_ack(in1_ack),
    .sel0_req(sel0_req), .sel0_val(sel0_val), .sel0_ack(sel0_ack),
    .sel1_req(sel1_req), .sel1_val(sel1_val), .sel1_ack(sel1_ack),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] acks();
    return {sel1_ack, sel0_ack, in1_ack, in0_ack};
  endfunction

  task automatic close_round();
    out_ack = 1; step();
    out_ack = 0;
    {in0_req, in1_req, sel0_req, sel1_req} = '0;
    sel0_val = 0; sel1_val = 0;
    step(); step(); step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R10 reset state
    chk("R10 out_req in reset", out_req, 0);
    chk("R10 out_data in reset", out_data, 0);
    chk("R10 acks in reset", acks(), 0);
    rst = 0; step();

    for (int v = 0; v < NV; v++) begin
      logic p0v, p1v;
      logic [DW-1:0] d0, d1, exp;
      {p0v, p1v, d0, d1} = VECS[v];
      exp = p0v ? d0 : (p1v ? d1 : held);
      // predicate 0 with its data alone
      in0_req = 1; in0_data = d0; sel0_req = 1; sel0_val = p0v;
      step();
      chk("R1 lenient fire on sel0", out_req, p0v);
      if (p0v) chk("R1 data from in0", out_data, d0);
      chk("R5 no ack before all inputs", acks(), 0);
      // remaining inputs
      in1_req = 1; in1_data = d1; sel1_req = 1; sel1_val = p1v;
      step();
      chk(p1v ? "R2 fire on sel1" : "R3 fire on out_req", out_req, 1);
      chk(p1v ? "R2 data from in1" : (p0v ? "R1 data held" : "R3 stale word"), out_data, exp);
      chk("R5 joint ack", acks(), 4'hF);
      out_ack = 1; step();
      chk("R7 out_req falls", out_req, 0);
      chk("R7 data stable", out_data, exp);
      out_ack = 0; step();
      chk("R9 no second fire", out_req, 0);
      in0_req = 0; step();
      chk("R6 individual release", acks(), 4'b1110);
      {in1_req, sel0_req, sel1_req} = '0; sel0_val = 0; sel1_val = 0;
      step();
      chk("R6 all released", acks(), 0);
      step();
      held = exp;
    end

    // R8: value bit without its request is ignored
    sel0_val = 1; in0_req = 1; in0_data = 8'hEE;
    sel1_req = 1; sel1_val = 0; in1_req = 1; in1_data = 8'hDD;
    step();
    chk("R8 val without req ignored", out_req, 0);
    sel0_val = 0; sel0_req = 1; step();
    chk("R8 false pred fires stale", out_req, 1);
    chk("R8 stale word kept", out_data, held);
    close_round();

    // R4: out_ack high blocks firing and acks
    out_ack = 1;
    in0_req = 1; in0_data = 8'h5A; sel0_req = 1; sel0_val = 1;
    in1_req = 1; in1_data = 8'h66; sel1_req = 1; sel1_val = 0;
    step();
    chk("R4 blocked by out_ack", out_req, 0);
    chk("R4 acks blocked", acks(), 0);
    out_ack = 0; step();
    chk("R4 fires after out_ack low", out_req, 1);
    chk("R1 data after release", out_data, 8'h5A);
    chk("R5 joint ack after release", acks(), 4'hF);
    close_round();

    // R10: reset mid-run clears held word
    rst = 1; step();
    chk("R10 reset clears data", out_data, 0);
    rst = 0; step();
    in0_req = 1; in0_data = 8'h12; in1_req = 1; in1_data = 8'h34;
    sel0_req = 1; sel1_req = 1;
    step();
    chk("R10 stale after reset req", out_req, 1);
    chk("R10 stale after reset is zero", out_data, 0);
    close_round();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule